// File: doc/BRIEF.md
# Average Inter-Packet Gap Controller

This block sits at the transmit output of an Ethernet MAC. It decides how many idle bytes must follow each frame, and it holds off the next frame start until that idle time has passed. The client reports each end of frame with a one-cycle pulse and the number of valid bytes in the last data word. The controller then computes the gap for that frame and asserts `hold` for as many cycles as the remaining idle bytes need.

In 10 Gb/s mode the next frame must start on a 4-byte lane boundary, so a single gap cannot always equal the target. A small running deficit count rounds each gap up or down to the boundary and carries the difference forward. Over many frames the mean gap therefore equals the target, and no single gap strays more than 3 bytes from it. In the 10/100/1000 Mb/s modes the data path moves one byte per cycle. There the gap is simply the programmed byte count.

Top module: `ipg_avg_ctrl`

## Requirements
- R1: After reset `hold` is 0, `idle_bytes` is 0 and the deficit count is 0. A reset in the middle of operation clears any deficit carried from earlier frames.
- R2: In 10 Gb/s mode (`speed_10g`=1) the target gap is 12 bytes when `cfg_gap_long`=1 and 8 bytes when `cfg_gap_long`=0.
- R3: When `cfg_unidir`=1, the 8-byte setting is rejected and the 10 Gb/s target is 12 bytes whatever `cfg_gap_long` holds.
- R4: In 10 Gb/s mode the chosen gap plus `eof_bytes` is a multiple of 4, so the next start falls on a 4-byte lane boundary.
- R5: In 10 Gb/s mode, let s = `eof_bytes` mod 4 and let D be the deficit (0..3).
  - If D+s ≤ 3, the gap is target−s and D becomes D+s.
  - Otherwise the gap is target−s+4 and D becomes D+s−4.
  - Every gap therefore lies between target−3 and target+3.
- R6: In lower-speed mode (`speed_10g`=0) the gap is `cfg_gap_low`. Values below 8 are treated as 8.
- R7: In lower-speed mode `eof_bytes` has no effect on the gap. The deficit is forced to 0 on every cycle spent in that mode.
- R8: After the cycle in which `eof_valid` is sampled high, `hold` is 1 for ceil(R/step) cycles and then 0.
  - In 10 Gb/s mode, R = max(0, gap − (8 − `eof_bytes`)) and step = 8.
  - In lower-speed mode, R = gap and step = 1.
- R9: `idle_bytes` shows the gap chosen for the most recent frame from the cycle after its `eof_valid`, and keeps that value until the next `eof_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eof_valid | input | 1 | One-cycle pulse marking the last word of a frame |
| eof_bytes | input | 4 | Valid bytes in the last word, 1..8 |
| speed_10g | input | 1 | 1: 10 Gb/s mode, 0: 10/100/1000 Mb/s mode |
| cfg_gap_long | input | 1 | 10 Gb/s target select: 1 = 12 bytes, 0 = 8 bytes |
| cfg_gap_low | input | 4 | Lower-speed gap in bytes (8..15) |
| cfg_unidir | input | 1 | Unidirectional operation; forces the 12-byte 10 Gb/s target |
| hold | output | 1 | Stall the next frame start |
| idle_bytes | output | 5 | Gap in bytes chosen for the last frame |

## Verification
The assertions take the following for granted about the inputs:
- `eof_valid` never rises while `hold` is high.
- `eof_bytes` lies in 1..8 whenever `eof_valid` is sampled.
- Speed and gap settings do not change while a hold window is counting down.

The stimulus keeps to these rules. It sends each frame end only after `hold` has dropped, and it changes mode or settings only in idle cycles. Frame-end byte counts are chosen to walk the deficit through every value 0..3, including the wrap that yields a longer gap and the case that leaves no hold cycle at all.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
    // Gap targets in bytes
    localparam int unsigned GAP_SHORT = 8;
    localparam int unsigned GAP_LONG  = 12;
    localparam int unsigned LOW_MIN   = 8;
    localparam int unsigned LOW_MAX   = 15;
endpackage

// File: rtl/ipg_target_sel.sv
module ipg_target_sel
    import ipg_pkg::*;
#(
    parameter int GAP_W = 5,
    parameter int LOW_W = 4
) (
    input  logic             speed_10g,
    input  logic             cfg_gap_long,
    input  logic [LOW_W-1:0] cfg_gap_low,
    input  logic             cfg_unidir,
    output logic [GAP_W-1:0] target
);
    logic [GAP_W-1:0] tgt_fast;
    logic [GAP_W-1:0] tgt_slow;
    logic [GAP_W-1:0] low_ext;

    always_comb begin
        // short average is refused in unidirectional operation
        tgt_fast = (cfg_gap_long || cfg_unidir) ? GAP_W'(GAP_LONG) : GAP_W'(GAP_SHORT);
        low_ext  = GAP_W'(cfg_gap_low);
        tgt_slow = (low_ext < GAP_W'(LOW_MIN)) ? GAP_W'(LOW_MIN) : low_ext;
        target   = speed_10g ? tgt_fast : tgt_slow;
    end
endmodule

// File: rtl/ipg_deficit.sv
module ipg_deficit #(
    parameter int ALIGN      = 4,   // lane group, power of two
    parameter int LANE_BYTES = 8,
    parameter int GAP_W      = 5,
    parameter int BYTES_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eof_valid,
    input  logic [BYTES_W-1:0] eof_bytes,
    input  logic               speed_10g,
    input  logic [GAP_W-1:0]   target,
    output logic [GAP_W-1:0]   gap
);
    localparam int DIC_W = $clog2(ALIGN);
    localparam int SUM_W = DIC_W + 1;

    typedef struct packed {
        logic [DIC_W-1:0] dic;
    } dic_state_t;

    dic_state_t       st_d, st_q;
    logic [DIC_W-1:0] short_b;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d    = st_q;
        gap     = target;
        short_b = eof_bytes[DIC_W-1:0];
        sum     = {1'b0, st_q.dic} + {1'b0, short_b};
        if (!speed_10g) begin
            st_d.dic = '0;
        end else if (sum <= SUM_W'(ALIGN - 1)) begin
            // round down to the boundary, remember the shortfall
            gap = target - GAP_W'(short_b);
            if (eof_valid) st_d.dic = sum[DIC_W-1:0];
        end else begin
            // deficit would overflow: stretch to next boundary
            gap = target - GAP_W'(short_b) + GAP_W'(ALIGN);
            if (eof_valid) st_d.dic = DIC_W'(sum - SUM_W'(ALIGN));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: next start lands on a lane boundary
    a_r4_lane_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && speed_10g) |-> (((int'(gap) + int'(eof_bytes)) % ALIGN) == 0));

    // R5: single gap within target +/- (ALIGN-1)
    a_r5_gap_window: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && speed_10g) |->
            ((int'(gap) + ALIGN - 1 >= int'(target)) && (int'(gap) <= int'(target) + ALIGN - 1)));

    // R7: deficit dropped in lower-speed mode
    a_r7_deficit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_10g |=> (st_q.dic == '0));
endmodule

// File: rtl/ipg_hold_timer.sv
module ipg_hold_timer #(
    parameter int LANE_BYTES = 8,
    parameter int GAP_W      = 5,
    parameter int BYTES_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eof_valid,
    input  logic [BYTES_W-1:0] eof_bytes,
    input  logic               speed_10g,
    input  logic [GAP_W-1:0]   gap,
    output logic               hold,
    output logic [GAP_W-1:0]   idle_bytes
);
    typedef struct packed {
        logic [GAP_W-1:0] rem;
        logic [GAP_W-1:0] idle;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [GAP_W-1:0] trail;
    logic [GAP_W-1:0] step;

    always_comb begin
        st_d  = st_q;
        // unused lanes of the last word already count as idle
        trail = speed_10g ? GAP_W'(LANE_BYTES) - GAP_W'(eof_bytes) : '0;
        step  = speed_10g ? GAP_W'(LANE_BYTES) : GAP_W'(1);
        if (eof_valid) begin
            st_d.idle = gap;
            st_d.rem  = (gap > trail) ? gap - trail : '0;
        end else begin
            st_d.rem  = (st_q.rem > step) ? st_q.rem - step : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold       = (st_q.rem != '0);
    assign idle_bytes = st_q.idle;

    // R8: input rule - no frame end while stalled
    a_r8_no_eof_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !eof_valid);

    // R8: full last word with a nonzero gap always stalls
    a_r8_hold_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && speed_10g && (int'(eof_bytes) == LANE_BYTES) && (gap != '0)) |=> hold);

    // R9: reported gap only changes on a frame end
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_valid |=> $stable(idle_bytes));

    // R6: lower-speed gaps stay in 8..15
    a_r6_low_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && !speed_10g) |=> (idle_bytes >= GAP_W'(8) && idle_bytes <= GAP_W'(15)));
endmodule

// File: rtl/ipg_avg_ctrl.sv
module ipg_avg_ctrl
    import ipg_pkg::*;
#(
    parameter int LANE_BYTES = 8,
    parameter int ALIGN      = 4,
    parameter int GAP_W      = 5,
    parameter int LOW_W      = 4,
    localparam int BYTES_W   = $clog2(LANE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eof_valid,
    input  logic [BYTES_W-1:0] eof_bytes,
    input  logic               speed_10g,
    input  logic               cfg_gap_long,
    input  logic [LOW_W-1:0]   cfg_gap_low,
    input  logic               cfg_unidir,
    output logic               hold,
    output logic [GAP_W-1:0]   idle_bytes
);
    logic [GAP_W-1:0] target;
    logic [GAP_W-1:0] gap;

    ipg_target_sel #(.GAP_W(GAP_W), .LOW_W(LOW_W)) u_tgt (
        .speed_10g    (speed_10g),
        .cfg_gap_long (cfg_gap_long),
        .cfg_gap_low  (cfg_gap_low),
        .cfg_unidir   (cfg_unidir),
        .target       (target)
    );

    ipg_deficit #(
        .ALIGN(ALIGN), .LANE_BYTES(LANE_BYTES), .GAP_W(GAP_W), .BYTES_W(BYTES_W)
    ) u_dic (
        .clk       (clk),
        .rst_n     (rst_n),
        .eof_valid (eof_valid),
        .eof_bytes (eof_bytes),
        .speed_10g (speed_10g),
        .target    (target),
        .gap       (gap)
    );

    ipg_hold_timer #(
        .LANE_BYTES(LANE_BYTES), .GAP_W(GAP_W), .BYTES_W(BYTES_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .eof_valid  (eof_valid),
        .eof_bytes  (eof_bytes),
        .speed_10g  (speed_10g),
        .gap        (gap),
        .hold       (hold),
        .idle_bytes (idle_bytes)
    );

    // R3: unidirectional forces the long target at 10G
    a_r3_unidir_long: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unidir && speed_10g) |-> (target == GAP_W'(GAP_LONG)));

    // R2: 10G target is one of the two legal averages
    a_r2_fast_target: assert property (@(posedge clk) disable iff (!rst_n)
        speed_10g |-> (target == GAP_W'(GAP_LONG) || target == GAP_W'(GAP_SHORT)));

    // R1: nothing stalled right after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hold);
endmodule

// File: tb/ipg_avg_ctrl_tb.sv
`timescale 1ns/1ps
module ipg_avg_ctrl_tb;
    localparam int LB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eof_valid = 1'b0;
    logic [3:0] eof_bytes = 4'd8;
    logic       speed_10g = 1'b1;
    logic       cfg_gap_long = 1'b1;
    logic [3:0] cfg_gap_low = 4'd12;
    logic       cfg_unidir = 1'b0;
    logic       hold;
    logic [4:0] idle_bytes;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ipg_avg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_bytes(eof_bytes),
        .speed_10g(speed_10g), .cfg_gap_long(cfg_gap_long), .cfg_gap_low(cfg_gap_low),
        .cfg_unidir(cfg_unidir), .hold(hold), .idle_bytes(idle_bytes)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference
    int m_dic = 0, m_rem = 0, m_idle = 0;
    int m_t, m_s, m_g, m_trail, m_step;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dic = 0; m_rem = 0; m_idle = 0;
        end else begin
            m_step = speed_10g ? LB : 1;
            if (eof_valid) begin
                if (speed_10g) begin
                    m_t = (cfg_gap_long || cfg_unidir) ? 12 : 8;
                    m_s = int'(eof_bytes) % 4;
                    if (m_dic + m_s <= 3) begin m_g = m_t - m_s; m_dic = m_dic + m_s; end
                    else begin m_g = m_t - m_s + 4; m_dic = m_dic + m_s - 4; end
                    m_trail = LB - int'(eof_bytes);
                end else begin
                    m_g = (int'(cfg_gap_low) < 8) ? 8 : int'(cfg_gap_low);
                    m_dic = 0; m_trail = 0;
                end
                m_idle = m_g;
                m_rem  = (m_g > m_trail) ? m_g - m_trail : 0;
            end else begin
                if (!speed_10g) m_dic = 0;
                m_rem = (m_rem > m_step) ? m_rem - m_step : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 hold vs model", int'(hold), int'(m_rem != 0));
            chk("R9 idle_bytes vs model", int'(idle_bytes), m_idle);
        end
    end

    function automatic int hold_len(input int g, input int nb, input bit fast);
        int st, tr, r;
        st = fast ? LB : 1;
        tr = fast ? LB - nb : 0;
        r  = (g > tr) ? g - tr : 0;
        return (r + st - 1) / st;
    endfunction

    task automatic send(input int nb, input int exp_gap, input string tag);
        int n;
        @(negedge clk);
        eof_valid = 1'b1;
        eof_bytes = 4'(nb);
        @(negedge clk);
        eof_valid = 1'b0;
        chk({tag, " gap"}, int'(idle_bytes), exp_gap);
        n = 0;
        while (hold) begin
            n++;
            @(negedge clk);
        end
        chk({"R8 hold cycles ", tag}, n, hold_len(exp_gap, nb, speed_10g));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold after reset", int'(hold), 0);
        chk("R1 idle after reset", int'(idle_bytes), 0);

        // 12-byte target, walk the deficit
        send(8, 12, "R2 long");
        send(5, 11, "R5 dic0->1");
        send(3, 13, "R5 wrap dic1->0");
        send(7, 9,  "R4 R5 dic0->3");
        send(6, 14, "R5 wrap dic3->1");
        // 8-byte target
        cfg_gap_long = 1'b0;
        send(8, 8,  "R2 short");
        send(1, 7,  "R5 dic1->2 no hold");
        send(2, 10, "R4 R5 wrap dic2->0");
        // unidirectional refuses 8
        cfg_unidir = 1'b1;
        send(8, 12, "R3 unidir");
        cfg_unidir = 1'b0;
        cfg_gap_long = 1'b1;
        send(5, 11, "R5 dic0->1 pre-low");
        // lower speed
        @(negedge clk);
        speed_10g = 1'b0;
        cfg_gap_low = 4'd10;
        send(3, 10, "R6 low 10");
        send(8, 10, "R7 eof_bytes ignored");
        cfg_gap_low = 4'd3;
        send(1, 8, "R6 clamp to 8");
        cfg_gap_low = 4'd15;
        send(4, 15, "R6 low 15");
        // back to 10G: deficit must be 0
        @(negedge clk);
        speed_10g = 1'b1;
        send(7, 9, "R7 deficit cleared");
        // reset clears carried deficit (now 3)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold after mid reset", int'(hold), 0);
        chk("R1 idle after mid reset", int'(idle_bytes), 0);
        send(7, 9, "R1 deficit reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule